// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block moves one byte at a time over a three-wire synchronous serial link: a data output, a data input and a shift clock that the block either drives itself or takes from the far end. Each accepted transmit byte starts one transfer. The byte is shifted out while a byte is shifted in on the same clock. The received byte is then handed back, the busy flag drops, and a single-cycle completion pulse is raised for an interrupt controller.

Four plain configuration inputs pick the clock source, the active clock edge, the bit order and the internal bit rate. All four are captured when a transfer is accepted and hold for the whole transfer. Between transfers they act at once on the idle clock level and on the clock driver enable. The transmit side is a valid/ready sink. `tx_ready` is low while a transfer runs, and also while a received byte is offered but not yet taken. A pending result is therefore never overwritten. The receive side is a valid/ready source. `rx_valid` and `rx_data` hold steady until `rx_ready` is seen high.

Top module: `ser_shift_port`

## Requirements
- R1: After reset `busy`, `rx_valid` and `done_irq` are 0 and `tx_ready` is 1. With internal clock and rising active edge selected, `sclk_o` is 1 and `sclk_oe` is 1.
- R2: With `cfg_lsb_first`=0 the transmit byte leaves bit 7 first, and the first received bit lands in bit 7 of `rx_data`.
- R3: With `cfg_lsb_first`=1 the transmit byte leaves bit 0 first, and the first received bit lands in bit 0 of `rx_data`.
- R4: `cfg_neg_edge`=0 makes the rising clock edge active and `cfg_neg_edge`=1 the falling one. `sdi` is sampled on active edges. `sdo` changes only on the other edge. When idle, the generated clock rests at 1 for rising-active and at 0 for falling-active.
- R5: In internal-clock mode one bit lasts N system cycles. `cfg_rate` 0, 1, 2, 3 give N = 512, 256, 128, 32. Codes 4 to 7 give N = 16. The clock spends N/2 cycles at each level.
- R6: With `cfg_ext_clk`=1, `sclk_oe` is 0. Edges of `sclk_i` drive the transfer after a two-flop synchroniser, and `sdi` passes through a matching two-flop stage.
- R7: On the eighth active edge `busy` clears. In the same cycle `rx_valid` rises with the received byte in `rx_data`. `done_irq` is high for exactly that one cycle.
- R8: A transfer starts only in a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` is 0 while busy, and also while `rx_valid` is 1 and `rx_ready` is 0. `rx_valid` and `rx_data` hold until a cycle with `rx_ready` high.
- R9: Configuration changes made during a transfer do not affect its bit order or bit rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_clk | input | 1 | 1: shift clock comes from `sclk_i`; 0: generated internally |
| cfg_neg_edge | input | 1 | 1: falling edge active; 0: rising edge active |
| cfg_lsb_first | input | 1 | 1: bit 0 first; 0: bit 7 first |
| cfg_rate | input | 3 | Internal bit-rate divider select |
| tx_valid | input | 1 | Transmit byte offered / start request |
| tx_ready | output | 1 | Transfer may be accepted |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Generated shift clock |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| sclk_i | input | 1 | Shift clock from the pin |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The hardest state to reach is a change of configuration in the middle of a running transfer. The bench reaches it by flipping the bit order and the rate code a few cycles after a start, then checking that both the byte seen by its peer model and the measured bit period still follow the values in force at the start. A second hard case is back-pressure on the result. The bench holds `rx_ready` low through a completed transfer, then keeps `tx_valid` high for many cycles, and confirms that no new transfer begins and that the pending byte does not move. Slave mode is driven by a bench clock that is slower than the synchroniser delay, so every edge is seen exactly once.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int unsigned SSP_RATE_W  = 3;
  localparam int unsigned SSP_MAX_LOG = 9;

  typedef struct packed {
    logic                  ext_clk;
    logic                  neg_edge;
    logic                  lsb_first;
    logic [SSP_RATE_W-1:0] rate;
  } ssp_cfg_t;

  // log2 of the bit period in system cycles for each rate code
  function automatic logic [3:0] ssp_div_log2(input logic [SSP_RATE_W-1:0] code);
    case (code)
      3'd0:    return 4'd9;
      3'd1:    return 4'd8;
      3'd2:    return 4'd7;
      3'd3:    return 4'd5;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ssp_baud_gen.sv
module ssp_baud_gen
  import ssp_pkg::*;
#(
  parameter int unsigned MAX_LOG = SSP_MAX_LOG,
  localparam int unsigned CNT_W  = MAX_LOG - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  idle_lvl,
  input  logic [SSP_RATE_W-1:0] rate,
  output logic                  sclk,
  output logic                  rise_p,
  output logic                  fall_p
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] half_cnt;
  logic [CNT_W:0]   lim_wide;
  logic [CNT_W-1:0] half_lim;
  logic [3:0]       shamt;
  logic             tick;
  logic             sclk_q;

  always_comb begin
    shamt    = ssp_div_log2(rate) - 4'd1;
    lim_wide = (ONE << shamt) - ONE;
    half_lim = lim_wide[CNT_W-1:0];
  end

  assign tick   = run && (half_cnt == half_lim);
  assign rise_p = tick && !sclk_q;
  assign fall_p = tick &&  sclk_q;
  assign sclk   = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      sclk_q   <= 1'b1;
    end else if (!run) begin
      half_cnt <= '0;
      sclk_q   <= idle_lvl;
    end else if (tick) begin
      half_cnt <= '0;
      sclk_q   <= ~sclk_q;
    end else begin
      half_cnt <= half_cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdi_in,
  output logic sdi_s,
  output logic rise_p,
  output logic fall_p
);

  logic [STAGES-1:0] sck_pipe;
  logic [STAGES-1:0] sdi_pipe;
  logic              sck_last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe <= '0;
          sdi_pipe <= '0;
        end else begin
          sck_pipe <= sclk_in;
          sdi_pipe <= sdi_in;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sck_pipe <= '0;
          sdi_pipe <= '0;
        end else begin
          sck_pipe <= {sck_pipe[STAGES-2:0], sclk_in};
          sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b0;
    else        sck_last <= sck_pipe[STAGES-1];
  end

  assign sdi_s  = sdi_pipe[STAGES-1];
  assign rise_p =  sck_pipe[STAGES-1] && !sck_last;
  assign fall_p = !sck_pipe[STAGES-1] &&  sck_last;

endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core #(
  parameter int unsigned BITS  = 8,
  localparam int unsigned CNT_W = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            lsb_first,
  input  logic            act_p,
  input  logic            inact_p,
  input  logic            sdi_bit,
  output logic            sdo,
  output logic            last_p,
  output logic [BITS-1:0] rx_word
);

  logic [BITS-1:0]  tx_sr;
  logic [BITS-1:0]  rx_sr;
  logic [CNT_W-1:0] bit_cnt;
  logic [BITS-1:0]  tx_next;
  logic [BITS-1:0]  rx_next;

  always_comb begin
    if (lsb_first) begin
      tx_next = {1'b0, tx_sr[BITS-1:1]};
      rx_next = {sdi_bit, rx_sr[BITS-1:1]};
      sdo     = tx_sr[0];
    end else begin
      tx_next = {tx_sr[BITS-2:0], 1'b0};
      rx_next = {rx_sr[BITS-2:0], sdi_bit};
      sdo     = tx_sr[BITS-1];
    end
  end

  assign last_p  = act_p && (bit_cnt == CNT_W'(BITS - 1));
  assign rx_word = rx_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_sr   <= '0;
      bit_cnt <= '0;
    end else if (load) begin
      tx_sr   <= load_data;
      rx_sr   <= '0;
      bit_cnt <= '0;
    end else begin
      if (act_p) begin
        rx_sr   <= rx_next;
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
      // the first inactive edge only opens the frame; bit 0 is already out
      if (inact_p && (bit_cnt != '0)) tx_sr <= tx_next;
    end
  end

endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port
  import ssp_pkg::*;
#(
  parameter int unsigned BITS        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_LOG     = SSP_MAX_LOG
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_ext_clk,
  input  logic                  cfg_neg_edge,
  input  logic                  cfg_lsb_first,
  input  logic [SSP_RATE_W-1:0] cfg_rate,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  input  logic [BITS-1:0]       tx_data,
  output logic                  rx_valid,
  input  logic                  rx_ready,
  output logic [BITS-1:0]       rx_data,
  output logic                  busy,
  output logic                  done_irq,
  output logic                  sclk_o,
  output logic                  sclk_oe,
  input  logic                  sclk_i,
  output logic                  sdo,
  input  logic                  sdi
);

  ssp_cfg_t        cfg_live;
  ssp_cfg_t        cfg_q;
  ssp_cfg_t        cfg_eff;
  logic            busy_q;
  logic            rx_valid_q;
  logic [BITS-1:0] rx_data_q;
  logic            irq_q;
  logic            start;
  logic            gen_rise, gen_fall;
  logic            ext_rise, ext_fall;
  logic            sdi_sync;
  logic            rise_sel, fall_sel;
  logic            act_p, inact_p;
  logic            sdi_bit;
  logic            last_p;
  logic [BITS-1:0] rx_word;

  assign cfg_live = '{ext_clk:   cfg_ext_clk,
                      neg_edge:  cfg_neg_edge,
                      lsb_first: cfg_lsb_first,
                      rate:      cfg_rate};
  assign cfg_eff  = busy_q ? cfg_q : cfg_live;

  assign tx_ready = !busy_q && !(rx_valid_q && !rx_ready);
  assign start    = tx_valid && tx_ready;

  ssp_baud_gen #(.MAX_LOG(MAX_LOG)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q && !cfg_q.ext_clk),
    .idle_lvl (~cfg_eff.neg_edge),
    .rate     (cfg_q.rate),
    .sclk     (sclk_o),
    .rise_p   (gen_rise),
    .fall_p   (gen_fall)
  );

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_i),
    .sdi_in  (sdi),
    .sdi_s   (sdi_sync),
    .rise_p  (ext_rise),
    .fall_p  (ext_fall)
  );

  always_comb begin
    rise_sel = cfg_q.ext_clk ? ext_rise : gen_rise;
    fall_sel = cfg_q.ext_clk ? ext_fall : gen_fall;
    act_p    = busy_q && (cfg_q.neg_edge ? fall_sel : rise_sel);
    inact_p  = busy_q && (cfg_q.neg_edge ? rise_sel : fall_sel);
    sdi_bit  = cfg_q.ext_clk ? sdi_sync : sdi;
  end

  ssp_shift_core #(.BITS(BITS)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (tx_data),
    .lsb_first (cfg_q.lsb_first),
    .act_p     (act_p),
    .inact_p   (inact_p),
    .sdi_bit   (sdi_bit),
    .sdo       (sdo),
    .last_p    (last_p),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cfg_q      <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (rx_valid_q && rx_ready) rx_valid_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cfg_q  <= cfg_live;
      end else if (last_p) begin
        busy_q     <= 1'b0;
        rx_data_q  <= rx_word;
        rx_valid_q <= 1'b1;
        irq_q      <= 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign done_irq = irq_q;
  assign sclk_oe  = ~cfg_eff.ext_clk;

endmodule

// File: rtl/ssp_checks.sv
module ssp_checks #(
  parameter int unsigned BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done_irq,
  input logic            tx_valid,
  input logic            tx_ready,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [BITS-1:0] rx_data,
  input logic            sclk_o,
  input logic            sclk_oe,
  input logic            sdo,
  input logic            neg_q,
  input logic            ext_q
);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  p_irq_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));

  p_start_handshake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid && tx_ready));

  p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  p_sdo_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && sclk_oe && !$stable(sclk_o) && (sclk_o != neg_q)) |-> $stable(sdo));

  p_slave_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_q) |-> !sclk_oe);

endmodule

bind ser_shift_port ssp_checks #(.BITS(BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done_irq (done_irq),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .sclk_o   (sclk_o),
  .sclk_oe  (sclk_oe),
  .sdo      (sdo),
  .neg_q    (cfg_q.neg_edge),
  .ext_q    (cfg_q.ext_clk)
);

// File: tb/sim_ser_shift_port.sv
module sim_ser_shift_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ext_clk = 1'b0, cfg_neg_edge = 1'b0, cfg_lsb_first = 1'b0;
  logic [2:0] cfg_rate = 3'd4;
  logic       tx_valid = 1'b0, rx_ready = 1'b1, sclk_i = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, busy, done_irq, sclk_o, sclk_oe, sdo, sdi;
  logic [7:0] rx_data;

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, irq_cnt = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  // peer model state
  logic [7:0] peer_tx = 8'h00;
  bit peer_ext = 1'b0, peer_neg = 1'b0, peer_lsb = 1'b0, peer_arm = 1'b0;
  int m_idx = 0, m_bits = 0, m_last = 0, m_period = 0, s_idx = 0;
  logic [7:0] m_rx = 8'h00, s_rx = 8'h00;
  logic prev_s = 1'b1;

  function automatic logic pbit(input logic [7:0] b, input int k, input bit lsb);
    int j;
    j = (k > 7) ? 7 : k;
    return lsb ? b[j] : b[7-j];
  endfunction

  assign sdi = peer_ext ? pbit(peer_tx, s_idx, peer_lsb) : pbit(peer_tx, m_idx, peer_lsb);

  ser_shift_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_neg_edge(cfg_neg_edge),
    .cfg_lsb_first(cfg_lsb_first), .cfg_rate(cfg_rate), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .busy(busy), .done_irq(done_irq), .sclk_o(sclk_o),
    .sclk_oe(sclk_oe), .sclk_i(sclk_i), .sdo(sdo), .sdi(sdi)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int period_of(input logic [2:0] r);
    case (r)
      3'd0: return 512;
      3'd1: return 256;
      3'd2: return 128;
      3'd3: return 32;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk) cyc++;

  // master-mode peer: watches the generated clock at the falling system edge
  always @(negedge clk) begin
    if (peer_arm) begin
      m_idx = 0; m_bits = 0; m_last = 0; m_period = 0; m_rx = 8'h00;
      prev_s = sclk_o;
    end else begin
      if (!peer_ext && sclk_oe && (sclk_o != prev_s)) begin
        if (sclk_o == !peer_neg) begin
          m_rx = peer_lsb ? {sdo, m_rx[7:1]} : {m_rx[6:0], sdo};
          m_bits++;
          if (m_last != 0) m_period = cyc - m_last;
          m_last = cyc;
        end else if (m_bits > 0 && m_bits < 8) begin
          m_idx = m_bits;
        end
      end
      prev_s = sclk_o;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done_irq) begin
      irq_cnt++;
      chk(!busy, "R7 busy low during irq", busy, 0);
    end
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R7 unexpected rx byte", rx_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R7 rx_data vs peer byte", rx_data, e);
      end
    end
  end

  task automatic xfer(input logic [7:0] txb, input logic [7:0] pb, input bit ext,
                      input bit neg, input bit lsb, input logic [2:0] rate,
                      input bit disturb, input bit hold_rx, input string tag);
    int irq0;
    bit moved;
    bit act_lvl;
    act_lvl = !neg;
    @(negedge clk);
    cfg_ext_clk = ext; cfg_neg_edge = neg; cfg_lsb_first = lsb; cfg_rate = rate;
    sclk_i = act_lvl;
    peer_ext = ext; peer_neg = neg; peer_lsb = lsb; peer_tx = pb;
    s_idx = 0; s_rx = 8'h00;
    rx_ready = !hold_rx;
    repeat (4) @(negedge clk);
    peer_arm = 1'b1;
    repeat (2) @(negedge clk);
    peer_arm = 1'b0;
    exp_q.push_back(pb);
    irq0 = irq_cnt;
    tx_data = txb; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    chk(busy == 1'b1, "R8 start on handshake", busy, 1);
    if (disturb) begin
      repeat (3) @(negedge clk);
      cfg_lsb_first = !lsb; cfg_rate = 3'd0;
    end
    if (ext) begin
      chk(sclk_oe == 1'b0, "R6 clock driver off in slave mode", sclk_oe, 0);
      for (int k = 0; k < 8; k++) begin
        repeat (6) @(negedge clk);
        sclk_i = !act_lvl;
        s_idx = k;
        repeat (6) @(negedge clk);
        s_rx = lsb ? {sdo, s_rx[7:1]} : {s_rx[6:0], sdo};
        sclk_i = act_lvl;
      end
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    if (ext) chk(s_rx == txb, {tag, " byte seen by peer"}, s_rx, txb);
    else begin
      chk(m_rx == txb, {tag, " byte seen by peer"}, m_rx, txb);
      chk(m_period == period_of(rate), "R5 bit period", m_period, period_of(rate));
    end
    chk(irq_cnt == irq0 + 1, "R7 one irq per transfer", irq_cnt - irq0, 1);
    if (hold_rx) begin
      chk(rx_valid == 1'b1, "R8 result pending", rx_valid, 1);
      moved = 1'b0;
      tx_valid = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (busy || tx_ready || rx_data != pb) moved = 1'b1;
      end
      tx_valid = 1'b0;
      chk(!moved, "R8 no start and data held while unread", moved, 0);
      rx_ready = 1'b1;
      repeat (2) @(negedge clk);
      chk(rx_valid == 1'b0, "R8 result taken", rx_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(done_irq == 1'b0, "R1 done_irq", done_irq, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(sclk_o == 1'b1, "R1 idle clock", sclk_o, 1);
    chk(sclk_oe == 1'b1, "R1 clock driver", sclk_oe, 1);

    xfer(8'hA5, 8'h3C, 0, 0, 0, 3'd4, 0, 0, "R2 msb-first");
    xfer(8'h1E, 8'hC3, 0, 0, 1, 3'd3, 0, 0, "R3 lsb-first");
    xfer(8'h96, 8'h71, 0, 1, 0, 3'd4, 0, 0, "R4 falling active");
    chk(sclk_o == 1'b0, "R4 idle low when falling active", sclk_o, 0);
    xfer(8'h4D, 8'hB2, 0, 1, 1, 3'd4, 0, 0, "R4 falling lsb");
    cfg_neg_edge = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk_o == 1'b1, "R4 idle high when rising active", sclk_o, 1);
    xfer(8'hC6, 8'h5A, 1, 0, 0, 3'd4, 0, 0, "R6 slave msb");
    xfer(8'h2B, 8'hE1, 1, 1, 1, 3'd4, 0, 0, "R6 slave lsb falling");
    for (int r = 0; r < 8; r++) begin
      if (r == 5 || r == 6) continue;
      xfer(8'h81 ^ 8'(r), 8'h18 ^ 8'(r), 0, 0, 0, 3'(r), 0, 0, "R5 rate code");
    end
    xfer(8'h6E, 8'h93, 0, 0, 0, 3'd4, 0, 1, "R8 back-pressure");
    xfer(8'hD4, 8'h0F, 0, 0, 0, 3'd3, 1, 0, "R9 config held");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all results delivered", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule